// File: doc/BRIEF.md
# Serial Register Read Front End

This block is the read side of the serial port of a ten-channel monitoring device. A host lowers chip select, clocks in an 8-bit header on the data input, and then keeps clocking to receive the requested register contents on the data output, most significant bit first. The header carries a 4-bit operation code first and a 4-bit channel number second. The register contents come from parallel input ports that the rest of the device drives: one 10-bit current value per channel, one 10-bit upper limit and one 10-bit lower limit per channel, one 8-bit setup byte per channel, and a 24-bit alarm word.

The block runs on a fast system clock. It brings the serial pins into that clock domain and detects the serial clock edges there. Input bits are taken on the rising serial clock edge, and the output bit changes on the falling edge. When the last header bit arrives, the block builds the whole reply from the parallel ports in one step. From then on it shifts out that fixed copy, so any port changes made during the reply do not alter it.

Channel numbers 0 to 9 map to the packed port slices 0 to 9. Number 0 is the on-die temperature channel, 1 is the supply monitor, and 2 through 9 are analog inputs 0 through 7.

Top module: `srd_read_if`

## Requirements
- R1: Bits are taken on the rising serial clock edge while chip select (active low) is low. The first four bits form the operation code and the next four the channel number, both MSB first. The data output is 0 for the whole 8-bit header, and the first reply bit appears after the falling edge that follows the eighth rising edge.
- R2: Operation code 4'b0001 returns the 24-bit alarm word, MSB first, whatever the channel number.
- R3: Operation code 4'b0010 returns one 16-bit field holding the current value of the addressed channel. The 10-bit value fills bits 9..0 of the field, and bits 15..10 are 0.
- R4: Operation code 4'b0011 ignores the channel number and returns ten 16-bit fields, formatted as in R3, for channels 0, 1, 2, ..., 9 in that order (temperature, supply, then inputs 0 to 7).
- R5: Operation code 4'b0100 returns 40 bits for the addressed channel: the upper limit in a 16-bit field, then the lower limit in a 16-bit field (both formatted as in R3), then the 8-bit setup byte.
- R6: Any other operation code, and any channel number from 10 to 15 with code 4'b0010 or 4'b0100, returns only 0 bits.
- R7: While chip select is high the data output is 0. Raising chip select at any point abandons the transfer, and the next low period starts a new header.
- R8: The reply is fixed from the parallel ports as they stand when the eighth header bit is taken. Later port changes in the same transfer have no effect on it.
- R9: After the last reply bit, further serial clocks in the same transfer return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial reply bit, 0 when idle |
| cur_data_i | input | NCH*VAL_W (100) | Current values, channel k in bits [k*10 +: 10] |
| upper_thr_i | input | NCH*VAL_W (100) | Upper limits, same packing |
| lower_thr_i | input | NCH*VAL_W (100) | Lower limits, same packing |
| chan_cfg_i | input | NCH*CFG_W (80) | Setup bytes, channel k in bits [k*8 +: 8] |
| alarm_i | input | ALM_W (24) | Alarm word |

## Verification
The hardest situation to reach from the ports is a parallel port change that lands after the reply has been fixed but while it is still being shifted out. The bench reaches it by rewriting every register input as soon as the header finishes. It then checks the whole 20-byte burst against values it recorded before the change. Aborted transfers are also driven on purpose, both partway through the header and partway through a burst, so the bench can confirm that the next header is decoded from a clean start. The selected-channel codes are swept over all sixteen channel numbers. The channel-free codes are sent with several channel numbers, and every unused code is exercised.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int unsigned SRD_FIELD_W = 16;
  localparam int unsigned SRD_HDR_W   = 8;

  typedef enum logic [3:0] {
    SRD_OP_ALARM = 4'h1,
    SRD_OP_ONE   = 4'h2,
    SRD_OP_ALL   = 4'h3,
    SRD_OP_CFG   = 4'h4
  } srd_op_e;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] chan;
  } srd_hdr_t;

  function automatic logic srd_op_known(input logic [3:0] op);
    return (op == SRD_OP_ALARM) || (op == SRD_OP_ONE) ||
           (op == SRD_OP_ALL)   || (op == SRD_OP_CFG);
  endfunction
endpackage

// File: rtl/srd_pin_sync.sv
module srd_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic din_i,
  output logic rise_o,
  output logic fall_o,
  output logic sel_o,
  output logic din_o
);
  logic [1:0] sclk_s;
  logic [1:0] cs_s;
  logic [1:0] din_s;
  logic       sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 2'b00;
      cs_s   <= 2'b11;
      din_s  <= 2'b00;
      sclk_d <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[0], sclk_i};
      cs_s   <= {cs_s[0], cs_n_i};
      din_s  <= {din_s[0], din_i};
      sclk_d <= sclk_s[1];
    end
  end

  assign sel_o  = ~cs_s[1];
  assign din_o  = din_s[1];
  assign rise_o = sel_o & sclk_s[1] & ~sclk_d;
  assign fall_o = sel_o & ~sclk_s[1] & sclk_d;

  // R1: each detected edge is a single-cycle pulse
  a_r1_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  a_r1_fall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/srd_frame_build.sv
module srd_frame_build
  import srd_pkg::*;
#(
  parameter int unsigned NCH   = 10,
  parameter int unsigned VAL_W = 10,
  parameter int unsigned CFG_W = 8,
  parameter int unsigned ALM_W = 24
) (
  input  srd_hdr_t                 hdr_i,
  input  logic [NCH*VAL_W-1:0]     cur_i,
  input  logic [NCH*VAL_W-1:0]     hi_i,
  input  logic [NCH*VAL_W-1:0]     lo_i,
  input  logic [NCH*CFG_W-1:0]     cfg_i,
  input  logic [ALM_W-1:0]         alarm_i,
  output logic [NCH*SRD_FIELD_W-1:0] frame_o
);
  localparam int unsigned FRAME_W = NCH * SRD_FIELD_W;
  localparam int unsigned SET_W   = 2 * SRD_FIELD_W + CFG_W;
  localparam int unsigned TOP     = FRAME_W - 1;

  function automatic logic [SRD_FIELD_W-1:0] pad_field(input logic [VAL_W-1:0] v);
    logic [SRD_FIELD_W-1:0] r;
    r = '0;
    r[VAL_W-1:0] = v;
    return r;
  endfunction

  logic             chan_ok;
  int unsigned      idx;
  logic [VAL_W-1:0] cur_sel, hi_sel, lo_sel;
  logic [CFG_W-1:0] cfg_sel;
  logic [FRAME_W-1:0] burst;

  assign chan_ok = (int'(hdr_i.chan) < int'(NCH));
  assign idx     = chan_ok ? int'(hdr_i.chan) : 0;
  assign cur_sel = cur_i[idx*VAL_W +: VAL_W];
  assign hi_sel  = hi_i[idx*VAL_W +: VAL_W];
  assign lo_sel  = lo_i[idx*VAL_W +: VAL_W];
  assign cfg_sel = cfg_i[idx*CFG_W +: CFG_W];

  for (genvar k = 0; k < NCH; k++) begin : g_burst
    assign burst[TOP - k*SRD_FIELD_W -: SRD_FIELD_W] = pad_field(cur_i[k*VAL_W +: VAL_W]);
  end

  always_comb begin
    frame_o = '0;
    case (hdr_i.op)
      SRD_OP_ALARM: frame_o[TOP -: ALM_W] = alarm_i;
      SRD_OP_ONE:   if (chan_ok) frame_o[TOP -: SRD_FIELD_W] = pad_field(cur_sel);
      SRD_OP_ALL:   frame_o = burst;
      SRD_OP_CFG:   if (chan_ok) frame_o[TOP -: SET_W] =
                      {pad_field(hi_sel), pad_field(lo_sel), cfg_sel};
      default:      frame_o = '0;
    endcase
  end
endmodule

// File: rtl/srd_shift_engine.sv
module srd_shift_engine
  import srd_pkg::*;
#(
  parameter int unsigned FRAME_W = 160
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               din_i,
  input  logic [FRAME_W-1:0] frame_i,
  output srd_hdr_t           hdr_nx_o,
  output logic               load_o,
  output logic               dout_o
);
  localparam int unsigned CNT_W = $clog2(SRD_HDR_W + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SRD_HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SRD_HDR_W - 1);

  logic [CNT_W-1:0]     cnt;
  logic [SRD_HDR_W-1:0] hdr;
  logic [FRAME_W-1:0]   shreg;
  logic                 hdr_done;

  assign hdr_done = (cnt == CNT_DONE);
  assign hdr_nx_o = {hdr[SRD_HDR_W-2:0], din_i};
  assign load_o   = sel_i & rise_i & (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      hdr    <= '0;
      shreg  <= '0;
      dout_o <= 1'b0;
    end else if (!sel_i) begin
      cnt    <= '0;
      hdr    <= '0;
      shreg  <= '0;
      dout_o <= 1'b0;
    end else begin
      if (rise_i && !hdr_done) begin
        hdr <= hdr_nx_o;
        cnt <= cnt + 1'b1;
      end
      if (load_o) begin
        shreg <= frame_i;
      end else if (fall_i && hdr_done) begin
        dout_o <= shreg[FRAME_W-1];
        shreg  <= {shreg[FRAME_W-2:0], 1'b0};
      end
    end
  end

  // R1: nothing leaves the port while the header is still arriving
  a_r1_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_done |-> !dout_o);
  // R1: the reply is fixed exactly as the header completes
  a_r1_load_ends_header: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> hdr_done);
  // R7: deselect returns the engine to idle
  a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> (!dout_o && cnt == '0));
  // R8: the captured reply only moves on a falling serial edge
  a_r8_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && hdr_done && !fall_i) |=> $stable(shreg));
endmodule

// File: rtl/srd_read_if.sv
module srd_read_if
  import srd_pkg::*;
#(
  parameter int unsigned NCH   = 10,
  parameter int unsigned VAL_W = 10,
  parameter int unsigned CFG_W = 8,
  parameter int unsigned ALM_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 din,
  output logic                 dout,
  input  logic [NCH*VAL_W-1:0] cur_data_i,
  input  logic [NCH*VAL_W-1:0] upper_thr_i,
  input  logic [NCH*VAL_W-1:0] lower_thr_i,
  input  logic [NCH*CFG_W-1:0] chan_cfg_i,
  input  logic [ALM_W-1:0]     alarm_i
);
  localparam int unsigned FRAME_W = NCH * SRD_FIELD_W;

  logic               rise, fall, sel, din_s, load;
  srd_hdr_t           hdr_nx;
  logic [FRAME_W-1:0] frame;

  srd_pin_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk),
    .cs_n_i (cs_n),
    .din_i  (din),
    .rise_o (rise),
    .fall_o (fall),
    .sel_o  (sel),
    .din_o  (din_s)
  );

  srd_frame_build #(
    .NCH(NCH), .VAL_W(VAL_W), .CFG_W(CFG_W), .ALM_W(ALM_W)
  ) u_build (
    .hdr_i   (hdr_nx),
    .cur_i   (cur_data_i),
    .hi_i    (upper_thr_i),
    .lo_i    (lower_thr_i),
    .cfg_i   (chan_cfg_i),
    .alarm_i (alarm_i),
    .frame_o (frame)
  );

  srd_shift_engine #(.FRAME_W(FRAME_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel),
    .rise_i   (rise),
    .fall_i   (fall),
    .din_i    (din_s),
    .frame_i  (frame),
    .hdr_nx_o (hdr_nx),
    .load_o   (load),
    .dout_o   (dout)
  );

  // R6: an unknown operation code captures an empty reply
  a_r6_unknown_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !srd_op_known(hdr_nx.op)) |-> (frame == '0));
  // R2: the alarm word lands at the head of the reply
  a_r2_alarm_head: assert property (@(posedge clk) disable iff (!rst_n)
    (load && hdr_nx.op == SRD_OP_ALARM) |-> (frame[FRAME_W-1 -: ALM_W] == alarm_i));
endmodule

// File: tb/srd_read_if_tb.sv
module srd_read_if_tb;
  localparam int NCH  = 10;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic din = 1'b0;
  logic dout;
  logic [NCH*10-1:0] cur_f, hi_f, lo_f;
  logic [NCH*8-1:0]  cfg_f;
  logic [23:0]       alarm_v;
  logic [9:0] cur_v [NCH];
  logic [9:0] hi_v  [NCH];
  logic [9:0] lo_v  [NCH];
  logic [7:0] cfg_v [NCH];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      cur_f[k*10 +: 10] = cur_v[k];
      hi_f[k*10 +: 10]  = hi_v[k];
      lo_f[k*10 +: 10]  = lo_v[k];
      cfg_f[k*8 +: 8]   = cfg_v[k];
    end
  end

  srd_read_if u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout),
    .cur_data_i(cur_f), .upper_thr_i(hi_f), .lower_thr_i(lo_f),
    .chan_cfg_i(cfg_f), .alarm_i(alarm_v)
  );

  task automatic set_pattern(input int salt);
    for (int k = 0; k < NCH; k++) begin
      cur_v[k] = 10'((k*149 + salt*37 + 5) % 1024);
      hi_v[k]  = 10'((k*61 + salt*11 + 700) % 1024);
      lo_v[k]  = 10'((k*23 + salt*71 + 3) % 1024);
      cfg_v[k] = 8'((k*29 + salt*13 + 1) % 256);
    end
    alarm_v = 24'h5A3C0F ^ 24'(salt * 40503);
  endtask

  function automatic int reply_len(input logic [3:0] c);
    case (c)
      4'h1: return 24;
      4'h2: return 16;
      4'h3: return 160;
      4'h4: return 40;
      default: return 16;
    endcase
  endfunction

  function automatic logic exp_bit(input logic [3:0] c, input logic [3:0] a, input int i);
    int pos;
    int ch;
    case (c)
      4'h1: return (i < 24) ? alarm_v[23-i] : 1'b0;
      4'h2: begin
        if (a > 9 || i >= 16) return 1'b0;
        pos = 15 - i;
        return (pos < 10) ? cur_v[a][pos] : 1'b0;
      end
      4'h3: begin
        if (i >= 160) return 1'b0;
        ch = i / 16;
        pos = 15 - (i % 16);
        return (pos < 10) ? cur_v[ch][pos] : 1'b0;
      end
      4'h4: begin
        if (a > 9 || i >= 40) return 1'b0;
        if (i < 16) begin pos = 15 - i; return (pos < 10) ? hi_v[a][pos] : 1'b0; end
        if (i < 32) begin pos = 31 - i; return (pos < 10) ? lo_v[a][pos] : 1'b0; end
        return cfg_v[a][39 - i];
      end
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_header(input logic [3:0] c, input logic [3:0] a, output bit quiet);
    logic [7:0] h;
    h = {c, a};
    quiet = 1;
    for (int b = 0; b < 8; b++) begin
      din = h[7-b];
      #HALF;
      if (dout !== 1'b0) quiet = 0;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
    din = 1'b0;
  endtask

  task automatic run(input logic [3:0] c, input logic [3:0] a, input int nbits,
                     input int new_salt, input string tag);
    logic [255:0] got;
    logic [255:0] exp;
    bit quiet;
    got = '0;
    exp = '0;
    for (int i = 0; i < nbits; i++) exp[i] = exp_bit(c, a, i);
    cs_n = 1'b0;
    #HALF;
    send_header(c, a, quiet);
    check("R1 header quiet", {255'b0, quiet}, 256'd1);
    if (new_salt >= 0) set_pattern(new_salt);
    for (int i = 0; i < nbits; i++) begin
      #HALF;
      got[i] = dout;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
    #HALF;
    cs_n = 1'b1;
    #(2*HALF);
    check(tag, got, exp);
  endtask

  initial begin
    bit q;
    set_pattern(1);
    #1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    #(HALF);
    check("R7 reset idle", {255'b0, dout}, 256'd0);

    // R3 sweep of every channel number, tail of 8 bits checks R9 and R6
    for (int a = 0; a < 16; a++) run(4'h2, 4'(a), 24, -1, "R3 R6 R9 selected current");
    set_pattern(2);
    // R5 sweep
    for (int a = 0; a < 16; a++) run(4'h4, 4'(a), 48, -1, "R5 R6 R9 limits and setup");
    // R2 address ignored
    run(4'h1, 4'h0, 32, -1, "R2 R9 alarm chan0");
    run(4'h1, 4'h9, 32, -1, "R2 alarm chan9");
    run(4'h1, 4'hF, 32, -1, "R2 alarm chan15");
    // R4 address ignored, channel order
    set_pattern(3);
    run(4'h3, 4'h0, 168, -1, "R4 R9 burst chan0");
    run(4'h3, 4'h7, 168, -1, "R4 burst chan7");
    run(4'h3, 4'hC, 168, -1, "R4 burst chan12");
    // R6 unused codes
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 4) continue;
      run(4'(c), 4'h3, 24, -1, "R6 unused code");
    end
    // R8 ports rewritten right after the header
    set_pattern(4);
    run(4'h3, 4'h0, 160, 5, "R8 burst snapshot");
    run(4'h3, 4'h0, 160, -1, "R8 new values seen");
    run(4'h4, 4'h6, 40, 6, "R8 setup snapshot");
    // R7 abort inside header
    cs_n = 1'b0;
    #HALF;
    for (int b = 0; b < 5; b++) begin
      din = 1'b1; #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
    #HALF;
    cs_n = 1'b1;
    #(2*HALF);
    check("R7 idle after abort", {255'b0, dout}, 256'd0);
    run(4'h2, 4'h5, 16, -1, "R7 clean restart after header abort");
    // R7 abort inside burst
    run(4'h3, 4'h0, 37, -1, "R7 partial burst");
    check("R7 idle after burst abort", {255'b0, dout}, 256'd0);
    run(4'h1, 4'h2, 24, -1, "R7 clean restart after burst abort");
    q = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule